// File: doc/BRIEF.md
# Programmable-Priority Interrupt Winner Resolver

This block picks, among the interrupt sources that are currently pending and enabled, the one with the highest priority in each of two delivery classes: the fast class and the normal class. Priority does not come from the source number. It comes from a table of 40 programmable slots. Each slot names one source and carries a valid flag. Slot 0 ranks first and slot 39 ranks last.

Pending, enable and class-route vectors arrive as inputs from the surrounding interrupt controller core. Software reaches the slots and a read-only status word through a simple 32-bit register port. The status word reports the winner of each class side by side.

The register port has a small read-response state machine with two states:
- `PORT_IDLE`: no read data is being returned.
- `PORT_RESP`: the captured read data is valid.

Its transitions are:
- `IDLE_TO_RESP`: a read strobe while in `PORT_IDLE`.
- `RESP_HOLD`: another read strobe while in `PORT_RESP`, so the machine stays in `PORT_RESP`.
- `RESP_TO_IDLE`: no read strobe while in `PORT_RESP`.

Writes take effect in either state.

Top module: `prio_resolver`

## Requirements
- R1: After reset every slot reads 0x00000000 and the status word (offset 0x18) reads 0x003F003F.
- R2: A slot keeps only bit 31 (valid) and bits 5:0 (source number); every other written bit reads back as 0.
- R3: Slot k sits at byte offset 0x1C+4k for k below 32 and at 0xB0+4(k-32) for k from 32 to 39. Each slot is stored independently of the others.
- R4: The status word has bit 31 set when a normal-class winner exists, with that winner's number in bits 21:16. It has bit 15 set when a fast-class winner exists, with that winner's number in bits 5:0. All other bits are 0. A class with no winner reports number 0x3F and a clear found bit.
- R5: A slot takes part in resolution only if its valid bit is 1 and its source number is below 40.
- R6: A source is a candidate only when its pending bit and its enable bit are both 1.
- R7: A candidate whose route bit is 1 competes in the fast class. A candidate whose route bit is 0 competes in the normal class.
- R8: In each class the lowest-numbered participating slot whose source is a candidate of that class wins. The two classes are resolved independently.
- R9: If two participating slots name the same source, the lower-numbered slot decides the result.
- R10: Writes to the status word have no effect. A read of any offset that is neither a slot nor the status word returns 0.
- R11: Read data and the read-valid flag appear in the cycle after the read strobe, and back-to-back reads are each answered. Read-valid drops after a cycle with no read strobe, and the read data then holds its last value.
- R12: The status word returned by a read reflects the input vectors and slot contents present in the cycle of the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend_i | input | 40 | Pending bit per source |
| src_en_i | input | 40 | Enable bit per source |
| src_fast_i | input | 40 | Route bit per source: 1 = fast class, 0 = normal class |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| bus_rvalid_o | output | 1 | High while bus_rdata_o carries a fresh read result |

## Verification
The hardest case to reach from the ports is a status word whose two winners come from different slots, where a higher-ranked slot names a source that is active but routed to the other class, invalid, or out of range. Reaching it needs the slot table programmed first and the three input vectors set together. To get there, the stimulus programs a fixed slot layout containing an invalid slot, an out-of-range number, a duplicated source and a reversed ranking. It then walks a vector table that lights chosen sources in chosen classes and reads the status word in the same cycle the inputs change.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;

    localparam int ID_W      = 6;
    localparam int WORD_W    = 32;
    localparam int VALID_BIT = 31;
    localparam logic [ID_W-1:0]   NONE_ID   = 6'h3F;
    localparam logic [WORD_W-1:0] SLOT_KEEP = 32'h8000_003F;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_state_e;

    typedef struct packed {
        logic            found;
        logic [ID_W-1:0] id;
    } pick_t;

endpackage

// File: rtl/slot_bank.sv
module slot_bank
    import prio_res_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int AW        = 8,
    parameter int LO_COUNT  = 32,
    parameter int unsigned LO_BASE = 32'h1C,
    parameter int unsigned HI_BASE = 32'hB0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  addr,
    input  logic [WORD_W-1:0]              wr_data,
    output logic                           addr_hit,
    output logic [WORD_W-1:0]              slot_word,
    output logic [NUM_SLOTS-1:0]           slot_v,
    output logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id
);

    localparam int IDX_W    = $clog2(NUM_SLOTS);
    localparam int HI_COUNT = NUM_SLOTS - LO_COUNT;
    localparam int unsigned LO_END = LO_BASE + 4 * LO_COUNT;
    localparam int unsigned HI_END = HI_BASE + 4 * HI_COUNT;

    logic [31:0]                    a32;
    logic [IDX_W-1:0]               idx;
    logic [NUM_SLOTS-1:0]           v_q;
    logic [NUM_SLOTS-1:0][ID_W-1:0] id_q;

    assign a32 = 32'(addr);

    always_comb begin
        addr_hit = 1'b0;
        idx      = '0;
        if (a32[1:0] == 2'b00) begin
            if (a32 >= LO_BASE && a32 < LO_END) begin
                addr_hit = 1'b1;
                idx      = IDX_W'((a32 - LO_BASE) >> 2);
            end else if (HI_COUNT > 0 && a32 >= HI_BASE && a32 < HI_END) begin
                addr_hit = 1'b1;
                idx      = IDX_W'(LO_COUNT + ((a32 - HI_BASE) >> 2));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= '0;
            id_q <= '0;
        end else if (wr_en && addr_hit) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (idx == IDX_W'(s)) begin
                    v_q[s]  <= wr_data[VALID_BIT];
                    id_q[s] <= wr_data[ID_W-1:0];
                end
            end
        end
    end

    always_comb begin
        slot_word = '0;
        if (addr_hit) begin
            slot_word[VALID_BIT]  = v_q[idx];
            slot_word[ID_W-1:0]   = id_q[idx];
        end
    end

    assign slot_v  = v_q;
    assign slot_id = id_q;

    // R2
    slot_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_hit) |=>
            (v_q[$past(idx)] == $past(wr_data[VALID_BIT])) &&
            (id_q[$past(idx)] == $past(wr_data[ID_W-1:0])));

    // R3
    slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_hit) |=> $stable(v_q) && $stable(id_q));

endmodule

// File: rtl/class_picker.sv
module class_picker
    import prio_res_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int NUM_SRC   = 40,
    parameter bit ROUTE_SEL = 1'b0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SLOTS-1:0]           slot_v,
    input  logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id,
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_SRC-1:0]             route,
    output pick_t                          pick
);

    // scan from the lowest-ranked slot upward so the best slot overrides last
    always_comb begin
        pick.found = 1'b0;
        pick.id    = NONE_ID;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_v[s] && (32'(slot_id[s]) < NUM_SRC)) begin
                if (active[slot_id[s]] && (route[slot_id[s]] == ROUTE_SEL)) begin
                    pick.found = 1'b1;
                    pick.id    = slot_id[s];
                end
            end
        end
    end

    // R5
    pick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick.found |-> (32'(pick.id) < NUM_SRC));

    // R4
    pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick.found |-> (pick.id == NONE_ID));

    // R6
    pick_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick.found |-> active[pick.id]);

endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
    import prio_res_pkg::*;
#(
    parameter int AW = 8,
    parameter int unsigned STAT_OFF = 32'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic              slot_hit,
    input  logic [WORD_W-1:0] slot_word,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    port_state_e state_q, state_d;
    logic [WORD_W-1:0] sel_word;
    logic              stat_hit;

    assign stat_hit = (32'(addr) == STAT_OFF);

    always_comb begin
        if (slot_hit)      sel_word = slot_word;
        else if (stat_hit) sel_word = status_word;
        else               sel_word = '0;
    end

    always_comb begin
        unique case (state_q)
            PORT_IDLE: state_d = rd_en ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_d = rd_en ? PORT_RESP : PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PORT_IDLE: rd_valid = 1'b0;
            PORT_RESP: rd_valid = 1'b1;
            default:   rd_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end

    // R11
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R11
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid && $stable(rd_data));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !slot_hit && !stat_hit) |=> (rd_data == '0));

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_res_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int NUM_SRC   = 40,
    parameter int AW        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [NUM_SRC-1:0] src_fast_i,
    input  logic               bus_rd_i,
    input  logic               bus_wr_i,
    input  logic [AW-1:0]      bus_addr_i,
    input  logic [WORD_W-1:0]  bus_wdata_i,
    output logic [WORD_W-1:0]  bus_rdata_o,
    output logic               bus_rvalid_o
);

    localparam int NUM_CLASS = 2;  // class 0 = normal, class 1 = fast

    logic [NUM_SRC-1:0]             active;
    logic                           slot_hit;
    logic [WORD_W-1:0]              slot_word;
    logic [NUM_SLOTS-1:0]           slot_v;
    logic [NUM_SLOTS-1:0][ID_W-1:0] slot_id;
    pick_t [NUM_CLASS-1:0]          picks;
    logic [WORD_W-1:0]              status_word;

    assign active = src_pend_i & src_en_i;

    slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .AW        (AW)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_i),
        .addr      (bus_addr_i),
        .wr_data   (bus_wdata_i),
        .addr_hit  (slot_hit),
        .slot_word (slot_word),
        .slot_v    (slot_v),
        .slot_id   (slot_id)
    );

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        class_picker #(
            .NUM_SLOTS (NUM_SLOTS),
            .NUM_SRC   (NUM_SRC),
            .ROUTE_SEL (c[0])
        ) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .slot_v  (slot_v),
            .slot_id (slot_id),
            .active  (active),
            .route   (src_fast_i),
            .pick    (picks[c])
        );
    end

    assign status_word = {picks[0].found, 9'b0, picks[0].id,
                          picks[1].found, 9'b0, picks[1].id};

    port_ctrl #(
        .AW (AW)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (bus_rd_i),
        .addr        (bus_addr_i),
        .slot_hit    (slot_hit),
        .slot_word   (slot_word),
        .status_word (status_word),
        .rd_data     (bus_rdata_o),
        .rd_valid    (bus_rvalid_o)
    );

    // R7
    fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        picks[1].found |-> src_fast_i[picks[1].id]);

    // R7
    norm_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        picks[0].found |-> !src_fast_i[picks[0].id]);

endmodule

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;

    typedef struct packed {
        logic [39:0] pend;
        logic [39:0] en;
        logic [39:0] fast;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{40'h0, 40'h0, 40'h0, 32'h003F003F, 8'd4},
        '{40'h20, 40'h20, 40'h0, 32'h8005003F, 8'd7},
        '{40'h20, 40'h20, 40'h20, 32'h003F8005, 8'd7},
        '{40'h20, 40'h0, 40'h0, 32'h003F003F, 8'd6},
        '{40'h0, 40'h20, 40'h0, 32'h003F003F, 8'd6},
        '{40'h1020, 40'h1020, 40'h1000, 32'h8005800C, 8'd8},
        '{40'h8, 40'h8, 40'h0, 32'h8003003F, 8'd5},
        '{40'h80, 40'h80, 40'h0, 32'h003F003F, 8'd5},
        '{40'h80_0010_0000, 40'h80_0010_0000, 40'h0, 32'h8027003F, 8'd8},
        '{40'h21, 40'h21, 40'h0, 32'h8005003F, 8'd8},
        '{40'h21, 40'h21, 40'h21, 32'h003F8005, 8'd8},
        '{40'h21, 40'h21, 40'h01, 32'h80058000, 8'd8},
        '{40'h10_1000, 40'h10_1000, 40'h10_0000, 32'h800C8014, 8'd8},
        '{40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 40'h0, 32'h8005003F, 8'd8},
        '{40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 32'h003F8005, 8'd8},
        '{40'h1000, 40'h1000, 40'h0, 32'h800C003F, 8'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_pend_i = '0;
    logic [39:0] src_en_i = '0;
    logic [39:0] src_fast_i = '0;
    logic        bus_rd_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        bus_rvalid_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_resolver dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_pend_i   (src_pend_i),
        .src_en_i     (src_en_i),
        .src_fast_i   (src_fast_i),
        .bus_rd_i     (bus_rd_i),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .bus_rvalid_o (bus_rvalid_o)
    );

    function automatic logic [7:0] slot_addr(int k);
        if (k < 32) return 8'(8'h1C + 4 * k);
        return 8'(8'hB0 + 4 * (k - 32));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R11 idle rvalid", 32'(bus_rvalid_o), 32'd0);
        rd(8'h18, d); check("R1 status", d, 32'h003F003F);
        rd(8'h1C, d); check("R1 slot0", d, 32'h0);
        rd(8'hCC, d); check("R1 slot39", d, 32'h0);

        // R2 write mask
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, d); check("R2 all ones", d, 32'h8000_003F);
        wr(8'h30, 32'h7FFF_FFC0); rd(8'h30, d); check("R2 dropped bits", d, 32'h0);

        // R3 slot map
        for (int k = 0; k < 40; k++) wr(slot_addr(k), 32'h8000_0000 | 32'(k));
        for (int k = 0; k < 40; k++) begin
            rd(slot_addr(k), d);
            check("R3 slot readback", d, 32'h8000_0000 | 32'(k));
        end
        rd(8'h9C, d); check("R10 gap offset", d, 32'h0);
        rd(8'hD0, d); check("R10 past end", d, 32'h0);
        rd(8'h00, d); check("R10 offset 0", d, 32'h0);
        for (int k = 0; k < 40; k++) wr(slot_addr(k), 32'h0);

        // R10 status read-only
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); check("R10 status write ignored", d, 32'h003F003F);
        rd(8'h1C, d); check("R10 status write no slot", d, 32'h0);

        // program slot layout
        wr(slot_addr(0), 32'h8000_0005);
        wr(slot_addr(1), 32'h8000_000C);
        wr(slot_addr(2), 32'h0000_0003);
        wr(slot_addr(3), 32'h8000_0028);
        wr(slot_addr(4), 32'h8000_0003);
        wr(slot_addr(5), 32'h8000_0027);
        wr(slot_addr(6), 32'h8000_0000);
        wr(slot_addr(7), 32'h0000_0007);
        wr(slot_addr(32), 32'h8000_000C);
        wr(slot_addr(39), 32'h8000_0014);

        // R4 R5 R6 R7 R8 R9 R12: inputs change in the read cycle itself
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            src_pend_i = VECS[v].pend; src_en_i = VECS[v].en; src_fast_i = VECS[v].fast;
            bus_rd_i = 1'b1; bus_addr_i = 8'h18;
            @(negedge clk);
            bus_rd_i = 1'b0;
            total++;
            if (bus_rdata_o !== VECS[v].exp) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VECS[v].req, v, bus_rdata_o, VECS[v].exp);
            end
        end

        // R11 valid flag and hold
        src_pend_i = 40'h20; src_en_i = 40'h20; src_fast_i = 40'h0;
        rd(8'h18, d);
        check("R11 rvalid after read", 32'(bus_rvalid_o), 32'd1);
        @(negedge clk);
        src_fast_i = 40'h20;
        check("R11 rvalid drops", 32'(bus_rvalid_o), 32'd0);
        @(negedge clk);
        check("R11 data holds", bus_rdata_o, 32'h8005003F);
        rd(8'h18, d); check("R12 fresh status", d, 32'h003F8005);

        // R11 back-to-back reads
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = slot_addr(0);
        @(negedge clk);
        bus_addr_i = slot_addr(39);
        check("R11 b2b first", bus_rdata_o, 32'h8000_0005);
        check("R11 b2b valid", 32'(bus_rvalid_o), 32'd1);
        @(negedge clk);
        bus_rd_i = 1'b0;
        check("R11 b2b second", bus_rdata_o, 32'h8000_0014);

        // R1 reset clears slots again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        src_pend_i = '1; src_en_i = '1;
        rd(8'h18, d); check("R1 status after reset", d, 32'h003F003F);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule